// File: doc/BRIEF.md
# Single-Cycle Load/Store/Branch Processor Core

This block is a 32-bit processor core that completes one instruction per clock period. It supports four instruction classes: register-to-register arithmetic and logic, word load, word store and branch-on-equal. It contains the program counter, a 32-entry register file with two read ports and one write port, the control decoder, an ALU with a zero flag, a separate branch-target adder and the write-back selection. Instruction memory and data memory are small arrays inside the block.

The two memories are filled through a preload port that writes only while reset is held. Once reset is released, the core runs from address 0. Every architectural write is visible at the ports in the same cycle as the instruction that causes it: the register write strobe, destination and value, and the data-memory read strobe, write strobe, address and store data. The PC has two possible next values. The sequential update gives PC+4. The branch update gives PC+4 plus the scaled offset, and is used only when a branch-on-equal finds its operands equal.

Top module: `sc_core`

## Requirements
- R1: An active-high synchronous reset sets the PC to 0. Outside reset, every instruction that is not a taken branch advances the PC by 4.
- R2: Register-type instructions use opcode bits 31:26 = 0 and shamt bits 10:6 = 0. They write the register named by bits 15:11. Function field bits 5:0 select the operation: 0x20 add, 0x22 subtract (rs minus rt), 0x24 AND, 0x25 OR. The data-memory strobes stay low.
- R3: Load (opcode 0x23) reads the data word at address R[rs] + sign-extended bits 15:0 and writes it to the register named by bits 20:16. The read strobe is asserted.
- R4: Store (opcode 0x2B) writes R[rt] to address R[rs] + sign-extended bits 15:0. The write strobe is asserted and no register is written.
- R5: Branch-on-equal (opcode 0x04) subtracts R[rt] from R[rs]. When the result is zero, the next PC is PC+4 + (sign-extended bits 15:0 shifted left by 2). Otherwise the next PC is PC+4.
- R6: The memory read strobe and the memory write strobe are never high in the same cycle.
- R7: Register 0 always reads as zero. A write aimed at it is discarded.
- R8: Register and memory writes take effect at the rising edge that ends the cycle, so the very next instruction sees the new value.
- R9: An unrecognised opcode, or a register-type instruction with an unrecognised function or a nonzero shamt, writes nothing and advances the PC by 4.
- R10: Function 0x2A (set-less-than) writes 1 when R[rs] is less than R[rt] as signed numbers, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write enable, honoured only while rst is high |
| ld_imem | input | 1 | Preload target: 1 instruction memory, 0 data memory |
| ld_addr | input | LD_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| pc_o | output | 32 | Address of the current instruction |
| rf_we_o | output | 1 | Register write strobe of the current instruction |
| rf_waddr_o | output | 5 | Destination register number |
| rf_wdata_o | output | 32 | Write-back value |
| dm_re_o | output | 1 | Data-memory read strobe |
| dm_we_o | output | 1 | Data-memory write strobe |
| dm_addr_o | output | 32 | ALU result used as the data byte address |
| dm_wdata_o | output | 32 | Store data, R[rt] |

## Verification
The strobes, destination, write-back value and memory address of an instruction are combinational from the PC register, so they are due in the same cycle that instruction occupies. The PC change and the register or memory update become visible one rising edge later. The bench samples at each falling edge: it checks the current instruction's outputs there, then crosses exactly one rising edge and checks the new PC. An instruction that depends on a value written by the instruction just before it is therefore a check of the end-of-cycle write timing.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam logic [5:0] OPC_REG    = 6'h00;
    localparam logic [5:0] OPC_BEQ    = 6'h04;
    localparam logic [5:0] OPC_LOAD   = 6'h23;
    localparam logic [5:0] OPC_STORE  = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;
        logic    mem_read;
        logic    mem_write;
        logic    mem_to_reg;
        logic    dst_is_rd;
        logic    use_imm;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic [4:0] shamt,
    output ctrl_t      ctl
);
    always_comb begin
        ctl = '0;
        unique case (opcode)
            OPC_REG: begin
                if (shamt == 5'd0) begin
                    ctl.dst_is_rd = 1'b1;
                    ctl.reg_write = 1'b1;
                    unique case (funct)
                        FN_ADD:  ctl.alu_op = ALU_ADD;
                        FN_SUB:  ctl.alu_op = ALU_SUB;
                        FN_AND:  ctl.alu_op = ALU_AND;
                        FN_OR:   ctl.alu_op = ALU_OR;
                        FN_SLT:  ctl.alu_op = ALU_SLT;
                        default: ctl.reg_write = 1'b0;
                    endcase
                end
            end
            OPC_LOAD: begin
                ctl.reg_write  = 1'b1;
                ctl.mem_read   = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.use_imm    = 1'b1;
                ctl.alu_op     = ALU_ADD;
            end
            OPC_STORE: begin
                ctl.mem_write = 1'b1;
                ctl.use_imm   = 1'b1;
                ctl.alu_op    = ALU_ADD;
            end
            OPC_BEQ: begin
                ctl.branch = 1'b1;
                ctl.alu_op = ALU_SUB;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y,
    output logic          zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 32,
    parameter int RAW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic [RAW-1:0] ra1,
    input  logic [RAW-1:0] ra2,
    output logic [DW-1:0]  rd1,
    output logic [DW-1:0]  rd2,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [DW-1:0]  wd
);
    logic [DW-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs_q[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int NREG       = 32,
    parameter int LD_AW      = $clog2(IMEM_WORDS > DMEM_WORDS ? IMEM_WORDS : DMEM_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic             ld_imem,
    input  logic [LD_AW-1:0] ld_addr,
    input  logic [31:0]      ld_data,
    output logic [31:0]      pc_o,
    output logic             rf_we_o,
    output logic [4:0]       rf_waddr_o,
    output logic [31:0]      rf_wdata_o,
    output logic             dm_re_o,
    output logic             dm_we_o,
    output logic [31:0]      dm_addr_o,
    output logic [31:0]      dm_wdata_o
);
    localparam int DW  = 32;
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [DW-1:0] imem_q [IMEM_WORDS];
    logic [DW-1:0] dmem_q [DMEM_WORDS];
    logic [DW-1:0] pc_q, pc_plus4, br_target, pc_next;
    logic [DW-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, rd_data, wb_data;
    logic          alu_zero, take_branch;
    logic [4:0]    dst_reg;
    ctrl_t         ctl;

    assign instr   = imem_q[pc_q[IAW+1:2]];
    assign imm_ext = {{16{instr[15]}}, instr[15:0]};

    sc_ctrl u_ctrl (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .shamt  (instr[10:6]),
        .ctl    (ctl)
    );

    assign dst_reg = ctl.dst_is_rd ? instr[15:11] : instr[20:16];

    sc_regfile #(.DW(DW), .NREG(NREG), .RAW(5)) u_rf (
        .clk (clk),
        .ra1 (instr[25:21]),
        .ra2 (instr[20:16]),
        .rd1 (rs_val),
        .rd2 (rt_val),
        .we  (ctl.reg_write),
        .wa  (dst_reg),
        .wd  (wb_data)
    );

    assign alu_b = ctl.use_imm ? imm_ext : rt_val;

    sc_alu #(.DW(DW)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign rd_data = dmem_q[alu_y[DAW+1:2]];
    assign wb_data = ctl.mem_to_reg ? rd_data : alu_y;

    // PC update: a dedicated adder makes the branch target, so the ALU stays free for the compare
    assign pc_plus4    = pc_q + 32'd4;
    assign br_target   = pc_plus4 + {imm_ext[DW-3:0], 2'b00};
    assign take_branch = ctl.branch & alu_zero;
    assign pc_next     = take_branch ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if (ld_en && ld_imem) imem_q[ld_addr[IAW-1:0]] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            if (ld_en && !ld_imem) dmem_q[ld_addr[DAW-1:0]] <= ld_data;
        end else if (ctl.mem_write) begin
            dmem_q[alu_y[DAW+1:2]] <= rt_val;
        end
    end

    logic unused_bits;
    assign unused_bits = ^{pc_q[1:0], pc_q[DW-1:IAW+2], alu_y[1:0], alu_y[DW-1:DAW+2], ld_addr};

    assign pc_o       = pc_q;
    assign rf_we_o    = ctl.reg_write;
    assign rf_waddr_o = dst_reg;
    assign rf_wdata_o = wb_data;
    assign dm_re_o    = ctl.mem_read;
    assign dm_we_o    = ctl.mem_write;
    assign dm_addr_o  = alu_y;
    assign dm_wdata_o = rt_val;

    p_pc_reset_r1: assert property (@(posedge clk) rst |=> (pc_o == 32'd0));
    p_pc_step_r1: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] != OPC_BEQ) |=> (pc_o == $past(pc_o) + 32'd4));
    p_load_dst_r3: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_LOAD) |-> (dm_re_o && rf_we_o && rf_waddr_o == instr[20:16]));
    p_store_nowb_r4: assert property (@(posedge clk) disable iff (rst)
        dm_we_o |-> !rf_we_o);
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(dm_re_o && dm_we_o));
    p_r0_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0, ld_imem = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
    logic [4:0]  rf_waddr_o;
    logic        rf_we_o, dm_re_o, dm_we_o;
    int n_chk = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;

    sc_core dut_i (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_imem(ld_imem), .ld_addr(ld_addr),
        .ld_data(ld_data), .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
        .rf_wdata_o(rf_wdata_o), .dm_re_o(dm_re_o), .dm_we_o(dm_we_o),
        .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 5000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic put(input logic im, input int a, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_imem = im; ld_addr = 6'(a); ld_data = d;
        @(posedge clk);
    endtask

    task automatic wb(input string tag, input int pc, input int dst, input logic [31:0] val, input logic re);
        chk({tag, " pc"}, pc_o, 32'(pc));
        chk({tag, " rf_we"}, {31'd0, rf_we_o}, 32'd1);
        chk({tag, " dst"}, {27'd0, rf_waddr_o}, 32'(dst));
        chk({tag, " value"}, rf_wdata_o, val);
        chk({tag, " strobes"}, {30'd0, dm_re_o, dm_we_o}, {30'd0, re, 1'b0});
        step();
    endtask

    task automatic t_reset();
        chk("R1 pc after reset", pc_o, 32'd0);
    endtask

    task automatic t_loads();
        wb("R3 load r1", 0, 1, 32'd7, 1'b1);
        wb("R3 load r2", 4, 2, 32'hFFFF_FFFD, 1'b1);
    endtask

    task automatic t_alu_ops();
        wb("R2 R8 add", 8, 3, 32'd4, 1'b0);
        wb("R2 sub", 12, 4, 32'd10, 1'b0);
        wb("R2 and", 16, 5, 32'd5, 1'b0);
        wb("R2 or", 20, 6, 32'hFFFF_FFFF, 1'b0);
        wb("R10 slt true", 24, 7, 32'd1, 1'b0);
        wb("R10 slt false", 28, 8, 32'd0, 1'b0);
    endtask

    task automatic t_r0();
        wb("R7 write r0", 32, 0, 32'd14, 1'b0);
        wb("R7 r0 reads zero", 36, 9, 32'd7, 1'b0);
    endtask

    task automatic t_store();
        chk("R4 pc", pc_o, 32'd40);
        chk("R4 R6 strobes", {29'd0, rf_we_o, dm_re_o, dm_we_o}, 32'b001);
        chk("R4 address", dm_addr_o, 32'd8);
        chk("R4 data", dm_wdata_o, 32'd4);
        step();
        wb("R8 load after store", 44, 10, 32'd4, 1'b1);
    endtask

    task automatic t_unknown();
        chk("R9 pc", pc_o, 32'd48);
        chk("R9 no writes", {29'd0, rf_we_o, dm_re_o, dm_we_o}, 32'd0);
        step();
        chk("R9 R1 next pc", pc_o, 32'd52);
        chk("R9 bad funct no write", {31'd0, rf_we_o}, 32'd0);
        step();
        chk("R9 R1 pc after bad funct", pc_o, 32'd56);
    endtask

    task automatic t_branch();
        chk("R5 untaken strobes", {29'd0, rf_we_o, dm_re_o, dm_we_o}, 32'd0);
        step();
        chk("R5 untaken pc", pc_o, 32'd60);
        step();
        chk("R5 taken forward", pc_o, 32'd72);
        step();
        chk("R5 taken backward", pc_o, 32'd72);
        step();
        chk("R5 still looping", pc_o, 32'd72);
    endtask

    initial begin
        logic [31:0] prog [19];
        prog[0]  = enc_i(6'h23, 0, 1, 16'd0);
        prog[1]  = enc_i(6'h23, 0, 2, 16'd4);
        prog[2]  = enc_r(1, 2, 3, 6'h20);
        prog[3]  = enc_r(1, 2, 4, 6'h22);
        prog[4]  = enc_r(1, 2, 5, 6'h24);
        prog[5]  = enc_r(1, 2, 6, 6'h25);
        prog[6]  = enc_r(2, 1, 7, 6'h2A);
        prog[7]  = enc_r(1, 2, 8, 6'h2A);
        prog[8]  = enc_r(1, 1, 0, 6'h20);
        prog[9]  = enc_r(0, 1, 9, 6'h20);
        prog[10] = enc_i(6'h2B, 0, 3, 16'd8);
        prog[11] = enc_i(6'h23, 0, 10, 16'd8);
        prog[12] = enc_i(6'h3F, 1, 11, 16'd0);
        prog[13] = enc_r(1, 1, 12, 6'h3F);
        prog[14] = enc_i(6'h04, 1, 2, 16'd5);
        prog[15] = enc_i(6'h04, 1, 9, 16'd2);
        prog[16] = enc_r(1, 1, 13, 6'h20);
        prog[17] = enc_r(1, 1, 13, 6'h20);
        prog[18] = enc_i(6'h04, 0, 0, 16'hFFFF);
        step(); step();
        for (int i = 0; i < 19; i++) put(1'b1, i, prog[i]);
        put(1'b0, 0, 32'd7);
        put(1'b0, 1, 32'hFFFF_FFFD);
        put(1'b0, 2, 32'd0);
        @(negedge clk); ld_en = 1'b0;
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_loads();
        t_alu_ops();
        t_r0();
        t_store();
        t_unknown();
        t_branch();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule